// File: doc/BRIEF.md
# Parallel Scan Chain Test Controller

This block is a small sequential design in which every state flop is a mux-D scan cell, wrapped together with the sequencer that tests it. The functional state is a register of `N_CELLS` bits. On each functional update, every bit loads the bit below it rotated by one position, XORed with the matching bit of `func_in`. In test mode the cells are cut into `N_CHAINS` parallel scan chains. Each chain is `CHAIN_LEN` = ceil(N_CELLS / N_CHAINS) stages deep. The last chain holds only the leftover cells, and pad stages in front of them make up its depth.

A tester raises `test_mode` and pulses `start` with a pattern count. For each pattern the sequencer shifts the chains for `CHAIN_LEN` cycles, then drops `scan_en` for one capture cycle. The response of pattern p leaves on `scan_out` while pattern p+1 enters on `scan_in`. A final unload phase drains the last response, and `done` then rises. In a separate flush mode the chains shift continuously. A per-chain checker raises a sticky error bit when the stream coming out stops alternating.

Top module: `scan_test_ctrl`

## Requirements
- R1: With `test_mode` low, `scan_en` is 0 and on every clock the cells load `{func_out[N-2:0], func_out[N-1]} ^ func_in`; `func_out` always shows the cells.
- R2: While `scan_en` is 1, each chain moves one stage per clock from its `scan_in` pin toward its `scan_out` pin, and `scan_out` shows the last stage.
- R3: Chain k holds cells k*CHAIN_LEN upward, the lowest nearest `scan_in` and the highest driving `scan_out`. The bit shifted in first therefore lands at the `scan_out` end, reversing the serial order.
- R4: Between two shift phases `scan_en` is 0 for exactly one clock, and in that clock every cell loads its R1 functional value once.
- R5: Each captured response comes out during the next shift phase, highest cell of each chain first, one cell per clock, while the next pattern is loaded.
- R6: Every shift phase lasts `CHAIN_LEN` clocks on all chains. The short last chain has `CHAIN_LEN - len` pad stages at its `scan_in` end that take dummy bits.
- R7: A `start` with `test_mode` high and `flush_mode` low, in the idle or done state, latches `pat_count` = P. `done` rises P*(CHAIN_LEN+1)+CHAIN_LEN clocks later and holds until the next start or until `test_mode` falls.
- R8: A start with `pat_count` = 0 raises `done` one clock later with no shifting and no change to the cells.
- R9: In flush mode (`test_mode` and `flush_mode` high while idle), the chains shift every clock. After CHAIN_LEN+1 shifting clocks, `chain_err[k]` is set when two consecutive `scan_out[k]` values are equal. The bit stays set until the first clock of the next flush session.
- R10: A clean alternating flush stream reappears on `scan_out` CHAIN_LEN clocks after it enters and leaves `chain_err` at 0.
- R11: Lowering `test_mode` returns the sequencer to idle, so `done` and `scan_en` are 0, and a `start` pulse then has no effect.
- R12: After reset the cells, `scan_out`, `scan_en`, `done` and `chain_err` are all 0. Reset asserts asynchronously and is released on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Selects test operation |
| flush_mode | input | 1 | Requests continuous chain flush while idle |
| start | input | 1 | Starts a pattern run |
| pat_count | input | PAT_W | Number of patterns in the run |
| func_in | input | N_CELLS | Functional data input |
| scan_in | input | N_CHAINS | Serial input of each chain |
| func_out | output | N_CELLS | Current cell contents |
| scan_en | output | 1 | Shift (1) or functional load (0) select |
| scan_out | output | N_CHAINS | Serial output of each chain |
| done | output | 1 | Run complete |
| chain_err | output | N_CHAINS | Sticky per-chain flush error |

## Verification
Every result is registered, so the bench drives and samples only on falling edges, where outputs reflect the rising edge just before. After a start, the first shift bit is taken on the next rising edge. The loaded pattern is visible on `func_out` in the capture cycle, CHAIN_LEN edges later. The response is visible one edge after that, and its first unload bit appears at once on `scan_out`. In flush mode a bit entering on edge j is compared on `scan_out` after edge j+CHAIN_LEN-1, and error flags are read only after the CHAIN_LEN+1 fill edges plus the break have passed. `done` is checked low on every earlier sample and high exactly at the due cycle.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPTURE,
    ST_UNLOAD,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sel,
  input  logic d,
  input  logic si,
  output logic q
);
  logic q_nxt;

  always_comb begin
    if (en) q_nxt = sel ? si : d;
    else    q_nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  // R2: shift path takes the scan input
  p_shift_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en && sel |=> q == $past(si));
  // R1: functional path takes the data input
  p_func_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en && !sel |=> q == $past(d));
  // R4: no update outside shift or capture
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter int LEN   = 4,
  parameter int PAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             flush_mode,
  input  logic             start,
  input  logic [PAT_W-1:0] pat_count,
  output logic             shift_o,
  output logic             capture_o,
  output logic             done_o,
  output logic             flush_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(LEN - 1);

  seq_state_e       state, state_nxt;
  logic [CW-1:0]    cnt, cnt_nxt;
  logic [PAT_W-1:0] left, left_nxt;
  logic             go;

  assign go = start && !flush_mode;

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    left_nxt  = left;
    if (!test_mode) begin
      state_nxt = ST_IDLE;
      cnt_nxt   = '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (go) begin
            cnt_nxt   = '0;
            left_nxt  = pat_count;
            state_nxt = (pat_count == '0) ? ST_DONE : ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (cnt == LAST_CNT) begin
            cnt_nxt   = '0;
            state_nxt = ST_CAPTURE;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
        ST_CAPTURE: begin
          left_nxt  = left - 1'b1;
          state_nxt = (left == PAT_W'(1)) ? ST_UNLOAD : ST_SHIFT;
        end
        ST_UNLOAD: begin
          if (cnt == LAST_CNT) begin
            cnt_nxt   = '0;
            state_nxt = ST_DONE;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
        default: state_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      left  <= '0;
    end else begin
      state <= state_nxt;
      cnt   <= cnt_nxt;
      left  <= left_nxt;
    end
  end

  assign flush_o   = test_mode && flush_mode && (state == ST_IDLE);
  assign shift_o   = test_mode && ((state == ST_SHIFT) || (state == ST_UNLOAD) || flush_o);
  assign capture_o = test_mode && (state == ST_CAPTURE);
  assign done_o    = test_mode && (state == ST_DONE);

  // R4: capture never lasts two clocks
  p_capture_once_r4: assert property (@(posedge clk) disable iff (!rst_n || !test_mode)
    state == ST_CAPTURE |=> state != ST_CAPTURE);
  // R6: a shift phase is not cut short
  p_shift_len_r6: assert property (@(posedge clk) disable iff (!rst_n || !test_mode)
    state == ST_SHIFT && cnt != LAST_CNT |=> state == ST_SHIFT);
  // R8: zero patterns jump straight to done
  p_zero_pat_r8: assert property (@(posedge clk) disable iff (!rst_n || !test_mode)
    state == ST_IDLE && go && pat_count == '0 |=> state == ST_DONE);
  // R11: leaving test mode forces idle
  p_exit_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> state == ST_IDLE);
endmodule

// File: rtl/flush_chk.sv
module flush_chk #(
  parameter int N_CH = 3,
  parameter int LEN  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [N_CH-1:0] so,
  output logic [N_CH-1:0] err
);
  localparam int FW = $clog2(LEN + 2);
  localparam logic [FW-1:0] FILL = FW'(LEN + 1);

  logic [FW-1:0]   fill, fill_nxt;
  logic [N_CH-1:0] prev, prev_nxt, err_nxt;

  always_comb begin
    fill_nxt = fill;
    prev_nxt = prev;
    err_nxt  = err;
    if (!active) begin
      fill_nxt = '0;
    end else begin
      prev_nxt = so;
      if (fill != FILL) fill_nxt = fill + 1'b1;
      if (fill == '0)        err_nxt = '0;
      else if (fill == FILL) err_nxt = err | ~(so ^ prev);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      prev <= '0;
      err  <= '0;
    end else begin
      fill <= fill_nxt;
      prev <= prev_nxt;
      err  <= err_nxt;
    end
  end

  // R9: error bits are sticky inside a session
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active && fill != '0 |=> (err & $past(err)) == $past(err));
  // R9: a new session starts clean
  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active && fill == '0 |=> err == '0);
endmodule

// File: rtl/scan_test_ctrl.sv
module scan_test_ctrl #(
  parameter int N_CELLS  = 10,
  parameter int N_CHAINS = 3,
  parameter int PAT_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                test_mode,
  input  logic                flush_mode,
  input  logic                start,
  input  logic [PAT_W-1:0]    pat_count,
  input  logic [N_CELLS-1:0]  func_in,
  input  logic [N_CHAINS-1:0] scan_in,
  output logic [N_CELLS-1:0]  func_out,
  output logic                scan_en,
  output logic [N_CHAINS-1:0] scan_out,
  output logic                done,
  output logic [N_CHAINS-1:0] chain_err
);
  localparam int CHAIN_LEN = (N_CELLS + N_CHAINS - 1) / N_CHAINS;
  localparam int LAST_LEN  = N_CELLS - (N_CHAINS - 1) * CHAIN_LEN;

  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic shift, capture, flush_act;
  logic cell_en, cell_sel;
  logic [N_CELLS-1:0] cells, nxt;
  logic [N_CHAINS-1:0][CHAIN_LEN-1:0] stg, chain_si;

  scan_seq #(.LEN(CHAIN_LEN), .PAT_W(PAT_W)) u_seq (
    .clk(clk), .rst_n(rst_ni), .test_mode(test_mode), .flush_mode(flush_mode),
    .start(start), .pat_count(pat_count), .shift_o(shift), .capture_o(capture),
    .done_o(done), .flush_o(flush_act)
  );

  assign nxt      = {cells[N_CELLS-2:0], cells[N_CELLS-1]} ^ func_in;
  assign cell_en  = !test_mode || shift || capture;
  assign cell_sel = test_mode && shift;

  for (genvar k = 0; k < N_CHAINS; k++) begin : g_chain
    localparam int LEN = (k == N_CHAINS - 1) ? LAST_LEN : CHAIN_LEN;
    localparam int PAD = CHAIN_LEN - LEN;
    for (genvar s = 0; s < CHAIN_LEN; s++) begin : g_stage
      if (s == 0) begin : g_head
        assign chain_si[k][s] = scan_in[k];
      end else begin : g_link
        assign chain_si[k][s] = stg[k][s-1];
      end
      if (s < PAD) begin : g_pad
        scan_cell u_pad (
          .clk(clk), .rst_n(rst_ni), .en(shift), .sel(1'b1), .d(1'b0),
          .si(chain_si[k][s]), .q(stg[k][s])
        );
      end else begin : g_cell
        localparam int IDX = k * CHAIN_LEN + s - PAD;
        scan_cell u_cell (
          .clk(clk), .rst_n(rst_ni), .en(cell_en), .sel(cell_sel), .d(nxt[IDX]),
          .si(chain_si[k][s]), .q(stg[k][s])
        );
        assign cells[IDX] = stg[k][s];
      end
    end
    assign scan_out[k] = stg[k][CHAIN_LEN-1];
  end

  flush_chk #(.N_CH(N_CHAINS), .LEN(CHAIN_LEN)) u_flush (
    .clk(clk), .rst_n(rst_ni), .active(flush_act), .so(scan_out), .err(chain_err)
  );

  assign func_out = cells;
  assign scan_en  = shift;

  // R1: no shifting outside test mode
  p_func_noscan_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    !test_mode |-> !scan_en);
  // R7: done and shifting never overlap
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> !scan_en);
endmodule

// File: tb/tb_scan_test_ctrl.sv
module tb_scan_test_ctrl;
  localparam int N   = 10;
  localparam int NCH = 3;
  localparam int PW  = 4;
  localparam int L   = (N + NCH - 1) / NCH;
  localparam int LL  = N - (NCH - 1) * L;

  logic clk = 1'b0;
  logic rst_n, test_mode, flush_mode, start;
  logic [PW-1:0]  pat_count;
  logic [N-1:0]   func_in, func_out;
  logic [NCH-1:0] scan_in, scan_out, chain_err;
  logic scan_en, done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  scan_test_ctrl #(.N_CELLS(N), .N_CHAINS(NCH), .PAT_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .flush_mode(flush_mode),
    .start(start), .pat_count(pat_count), .func_in(func_in), .scan_in(scan_in),
    .func_out(func_out), .scan_en(scan_en), .scan_out(scan_out), .done(done),
    .chain_err(chain_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] f_next(input logic [N-1:0] s, input logic [N-1:0] fi);
    return {s[N-2:0], s[N-1]} ^ fi;
  endfunction

  function automatic int pad_of(input int k);
    return (k == NCH - 1) ? L - LL : 0;
  endfunction

  // serial bit for chain k at shift cycle c: stage L-1-c, dummy 1 on pads
  function automatic logic load_bit(input int k, input int c, input logic [N-1:0] p);
    int s = L - 1 - c;
    if (s < pad_of(k)) return 1'b1;
    return p[k * L + s - pad_of(k)];
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; test_mode = 1'b0; flush_mode = 1'b0; start = 1'b0;
    pat_count = '0; func_in = '0; scan_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(func_out == '0, "R12 cells", 32'(func_out), 0);
    chk(scan_out == '0 && chain_err == '0, "R12 scan_out/err", {scan_out, chain_err}, 0);
    chk(!scan_en && !done, "R12 scan_en/done", {scan_en, done}, 0);
  endtask

  task automatic t_functional();
    logic [N-1:0] exp = func_out;
    for (int i = 0; i < 6; i++) begin
      func_in = 10'h0A5 ^ (10'(i) * 10'h0C7);
      exp = f_next(exp, func_in);
      @(negedge clk);
      chk(func_out == exp, "R1 functional update", 32'(func_out), 32'(exp));
      chk(!scan_en, "R1 scan_en low", 32'(scan_en), 0);
    end
  endtask

  task automatic t_scan(input int np, input logic [N-1:0] fi);
    logic [N-1:0] pats [0:7];
    logic [N-1:0] resp [0:7];
    for (int p = 0; p < np; p++) pats[p] = 10'h2D5 ^ (10'(p) * 10'h13B);
    func_in = fi;
    test_mode = 1'b1;
    @(negedge clk);
    start = 1'b1; pat_count = PW'(np);
    for (int p = 0; p <= np; p++) begin
      for (int c = 0; c < L; c++) begin
        @(negedge clk);
        start = 1'b0;
        chk(scan_en, "R2 scan_en in shift", 32'(scan_en), 1);
        chk(!done, "R7 done early", 32'(done), 0);
        if (p > 0) begin
          if (c == 0) chk(func_out == resp[p-1], "R4 captured response", 32'(func_out), 32'(resp[p-1]));
          for (int k = 0; k < NCH; k++) begin
            int s = L - 1 - c;
            if (s >= pad_of(k))
              chk(scan_out[k] == resp[p-1][k * L + s - pad_of(k)], "R5 unload bit",
                  32'(scan_out[k]), 32'(resp[p-1][k * L + s - pad_of(k)]));
          end
        end
        for (int k = 0; k < NCH; k++) scan_in[k] = (p < np) ? load_bit(k, c, pats[p]) : 1'b0;
      end
      if (p < np) begin
        @(negedge clk);
        chk(!scan_en, "R4 capture scan_en low", 32'(scan_en), 0);
        chk(func_out == pats[p], "R3 loaded order", 32'(func_out), 32'(pats[p]));
        resp[p] = f_next(pats[p], fi);
      end
    end
    @(negedge clk);
    chk(done, "R7 done after run", 32'(done), 1);
    chk(!scan_en, "R6 shift ended", 32'(scan_en), 0);
    @(negedge clk);
    chk(done, "R7 done holds", 32'(done), 1);
  endtask

  task automatic t_exit_and_zero();
    logic [N-1:0] snap;
    test_mode = 1'b0;
    @(negedge clk);
    chk(!done && !scan_en, "R11 exit to idle", {done, scan_en}, 0);
    func_in = '0;
    snap = func_out;
    @(negedge clk);
    // hold cells steady from here on: func_in 0 keeps rotating, so track it
    snap = func_out;
    start = 1'b1; pat_count = 4'd2;
    @(negedge clk);
    start = 1'b0;
    snap = f_next(snap, '0);
    chk(func_out == snap, "R11 start ignored, cells functional", 32'(func_out), 32'(snap));
    @(negedge clk);
    chk(!done && !scan_en, "R11 start ignored", {done, scan_en}, 0);
    test_mode = 1'b1;
    @(negedge clk);
    snap = func_out;
    start = 1'b1; pat_count = '0;
    @(negedge clk);
    start = 1'b0;
    chk(done, "R8 zero patterns done", 32'(done), 1);
    chk(!scan_en, "R8 no shift", 32'(scan_en), 0);
    chk(func_out == snap, "R8 cells untouched", 32'(func_out), 32'(snap));
  endtask

  // one flush session of nb edges; chain 1 slips phase from edge brk when brk>0
  task automatic t_flush(input int nb, input int brk, input logic [NCH-1:0] exp_err);
    logic [NCH-1:0] hist [0:63];
    test_mode = 1'b1; flush_mode = 1'b0;
    @(negedge clk);
    flush_mode = 1'b1;
    for (int j = 1; j <= nb; j++) begin
      if (j > 1) begin
        chk(scan_en, "R9 flush shifts", 32'(scan_en), 1);
        if (j - 1 >= L && brk == 0)
          chk(scan_out == hist[j - L], "R10 stream delay", 32'(scan_out), 32'(hist[j - L]));
      end
      for (int k = 0; k < NCH; k++)
        hist[j][k] = (k == 1 && brk > 0 && j >= brk) ? ~j[0] : j[0];
      scan_in = hist[j];
      @(negedge clk);
    end
    chk(chain_err == exp_err, (brk > 0) ? "R9 break flagged" : "R10 clean flush",
        32'(chain_err), 32'(exp_err));
    flush_mode = 1'b0;
    @(negedge clk);
    chk(chain_err == exp_err, "R9 sticky after flush", 32'(chain_err), 32'(exp_err));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_functional();
    t_scan(3, 10'h155);
    t_scan(1, 10'h2AA);
    t_exit_and_zero();
    test_mode = 1'b0;
    @(negedge clk);
    t_flush(12, 0, 3'b000);
    t_flush(12, 6, 3'b010);
    t_flush(12, 0, 3'b000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule